// File: doc/BRIEF.md
# Clock-Master Synchronous Serial Receiver

This block receives serial data on a synchronous link where it is the clock source. It drives its own shift clock, divided from the system clock by a fixed factor, and samples one data input. Each frame of `DATA_W` bits is gathered in a shift register and then handed to the host through a receive buffer. A one-cycle interrupt pulse marks each delivery.

The host controls the receiver with three inputs. An enable bit starts and stops clocking. A buffer-mode bit selects single or double buffering. A read strobe consumes the buffered frame. The receiver never overruns. When the host falls behind, the shift clock is held idle until a read frees room. In double-buffer mode, that read also moves a waiting frame from the shift register into the buffer.

Top module: `ssr_rx`

## Requirements
- R1: After reset, `sclk` is 1, `buf_full` is 0 and `rx_irq` is 0.
- R2: `sclk` is produced only while `rx_en` is 1 and otherwise idles at 1. Each bit period is `2*SCLK_HALF` system cycles: low for the first `SCLK_HALF`, high for the second. `sdi` is sampled at the rising edge, and the first bit received becomes bit 7 (MSB first).
- R3: When the last bit of a frame has been shifted in and the buffer can take it, the frame appears on `rx_data`. In that same cycle `buf_full` becomes 1 and `rx_irq` pulses.
- R4: With `dbl_buf` = 0, no clock pulse for a new frame is produced while `buf_full` is 1. Clocking continues once the host has read.
- R5: With `dbl_buf` = 1, the next frame is clocked in while `buf_full` is 1.
- R6: With `dbl_buf` = 1, if a frame completes while the buffer is still unread, there is no `rx_irq`. `sclk` then stays at 1, and `rx_data` keeps the older frame.
- R7: In that stalled state, a `rd_strobe` moves the waiting frame into `rx_data` and pulses `rx_irq`, while `buf_full` stays 1. Clocking then resumes if `rx_en` is 1.
- R8: A `rd_strobe` while `buf_full` is 1 and no frame is waiting clears `buf_full` on the next cycle.
- R9: A `rd_strobe` while `buf_full` is 0 has no effect: `buf_full` stays 0 and no `rx_irq` follows.
- R10: Clearing `rx_en` lets the current bit period finish, after which `sclk` stays 1. The partial frame is dropped, and the next frame after re-enabling starts from its first bit.
- R11: `rx_irq` never lasts longer than one cycle, and `rx_data` changes only in a cycle where `rx_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; clocking runs while 1 |
| dbl_buf | input | 1 | 1 selects double buffering, 0 single |
| rd_strobe | input | 1 | One-cycle host read of the buffer |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Generated shift clock, idle high |
| rx_data | output | DATA_W | Receive buffer contents |
| buf_full | output | 1 | Buffer holds an unread frame |
| rx_irq | output | 1 | One-cycle pulse per delivered frame |

## Verification
The bench aims at the stall in double-buffer mode. A design that raised the interrupt there, or overwrote the buffer, would produce an extra or corrupted byte in the scoreboard. A design that failed to resume would never deliver the third frame. It also checks that a read releasing a stalled frame keeps the full flag set; a design that cleared the flag would look empty while holding data. An enable drop in mid-frame tests that the bit count restarts; a design that kept the partial bits would deliver a shifted byte. In single-buffer mode the bench counts clock edges while the buffer is unread, to catch a design that keeps clocking and would overrun.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  // per-cycle strobes produced by the clock generator
  typedef struct packed {
    logic sample;   // rising edge of sclk happens at this clock edge
    logic bit_end;  // last cycle of a bit period
  } ssr_tick_t;
endpackage

// File: rtl/ssr_clkgen.sv
module ssr_clkgen
  import ssr_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_ok,
  input  logic      cont_ok,
  output ssr_tick_t tick,
  output logic      sclk
);
  localparam int PH_W = (2 * SCLK_HALF > 2) ? $clog2(2 * SCLK_HALF) : 1;
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SCLK_HALF - 1);
  localparam logic [PH_W-1:0] PH_HIGH   = PH_W'(SCLK_HALF);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(2 * SCLK_HALF - 1);

  logic            active_q, active_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            sclk_q, sclk_d;

  always_comb begin
    tick.sample  = active_q && (ph_q == PH_SAMPLE);
    tick.bit_end = active_q && (ph_q == PH_LAST);
    active_d     = active_q;
    ph_d         = ph_q;
    if (!active_q) begin
      active_d = start_ok;
      ph_d     = '0;
    end else if (tick.bit_end) begin
      active_d = cont_ok;
      ph_d     = '0;
    end else begin
      ph_d = ph_q + 1'b1;
    end
    sclk_d = !(active_d && (ph_d < PH_HIGH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      sclk_q   <= 1'b1;
    end else begin
      active_q <= active_d;
      ph_q     <= ph_d;
      sclk_q   <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
  import ssr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssr_tick_t         tick,
  input  logic              sdi,
  input  logic              rx_en,
  output logic [DATA_W-1:0] shift_data,
  output logic              last_bit,
  output logic              frame_done
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    last_bit   = (cnt_q == CNT_LAST);
    frame_done = tick.bit_end && last_bit;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    if (tick.sample) sh_d = {sh_q[DATA_W-2:0], sdi};
    if (tick.bit_end) cnt_d = (last_bit || !rx_en) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign shift_data = sh_q;
endmodule

// File: rtl/ssr_bufctl.sv
module ssr_bufctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] shift_data,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_full,
  output logic              stalled,
  output logic              irq
);
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              full_q, full_d, stall_q, stall_d, irq_d, irq_q;
  logic              rd_eff;

  always_comb begin
    rd_eff = rd_strobe && full_q;
    buf_d  = buf_q;
    full_d = full_q;
    stall_d = stall_q;
    irq_d  = 1'b0;
    if (stall_q && rd_eff) begin
      buf_d   = shift_data;
      full_d  = 1'b1;
      stall_d = 1'b0;
      irq_d   = 1'b1;
    end else if (frame_done) begin
      if (!full_q || rd_eff) begin
        buf_d  = shift_data;
        full_d = 1'b1;
        irq_d  = 1'b1;
      end else begin
        stall_d = 1'b1;
      end
    end else if (rd_eff) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      stall_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      full_q  <= full_d;
      stall_q <= stall_d;
      irq_q   <= irq_d;
    end
  end

  assign buf_data = buf_q;
  assign buf_full = full_q;
  assign stalled  = stall_q;
  assign irq      = irq_q;
endmodule

// File: rtl/ssr_rx.sv
module ssr_rx
  import ssr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              dbl_buf,
  input  logic              rd_strobe,
  input  logic              sdi,
  output logic              sclk,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              rx_irq
);
  ssr_tick_t         tick;
  logic [DATA_W-1:0] shift_data;
  logic              last_bit, frame_done, stalled;
  logic              start_ok, cont_ok;

  // a new frame starts only when the buffer can eventually take it
  assign start_ok = rx_en && (dbl_buf ? !stalled : !buf_full);
  assign cont_ok  = rx_en && !last_bit;

  ssr_clkgen #(.SCLK_HALF(SCLK_HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .cont_ok(cont_ok),
    .tick(tick), .sclk(sclk)
  );

  ssr_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sdi(sdi), .rx_en(rx_en),
    .shift_data(shift_data), .last_bit(last_bit), .frame_done(frame_done)
  );

  ssr_bufctl #(.DATA_W(DATA_W)) u_bufctl (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .shift_data(shift_data),
    .rd_strobe(rd_strobe), .buf_data(rx_data), .buf_full(buf_full),
    .stalled(stalled), .irq(rx_irq)
  );
endmodule

// File: rtl/ssr_rx_chk.sv
module ssr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              dbl_buf,
  input logic              rd_strobe,
  input logic              sclk,
  input logic [DATA_W-1:0] rx_data,
  input logic              buf_full,
  input logic              rx_irq
);
  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq |-> $stable(rx_data));

  // R3
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> buf_full);

  // R3
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> rx_irq);

  // R8
  full_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $past(rd_strobe));

  // R2
  sclk_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $past(rx_en));

  // R4
  single_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && !$past(dbl_buf)) |-> !$past(buf_full));
endmodule

bind ssr_rx ssr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_buf(dbl_buf),
  .rd_strobe(rd_strobe), .sclk(sclk), .rx_data(rx_data),
  .buf_full(buf_full), .rx_irq(rx_irq)
);

// File: tb/tb_ssr_rx.sv
module tb_ssr_rx;
  localparam int DATA_W = 8;
  localparam int HALF   = 2;

  logic clk, rst_n, rx_en, dbl_buf, rd_strobe, sdi;
  logic sclk, buf_full, rx_irq;
  logic [DATA_W-1:0] rx_data;

  ssr_rx #(.DATA_W(DATA_W), .SCLK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_buf(dbl_buf),
    .rd_strobe(rd_strobe), .sdi(sdi), .sclk(sclk), .rx_data(rx_data),
    .buf_full(buf_full), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int fall_cnt = 0, irq_cnt = 0, cyc = 0, bit_idx = 0;
  logic prev_sclk = 1'b1, prev_irq = 1'b0;
  logic [DATA_W-1:0] cur_tx = '0;
  logic [DATA_W-1:0] tx_q[$];
  logic [DATA_W-1:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // driver: pushes a frame for the line and for the scoreboard
  task automatic send(input logic [DATA_W-1:0] b, input bit expect_it);
    tx_q.push_back(b);
    if (expect_it) exp_q.push_back(b);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(input int n, input string tag);
    int t = 0;
    while (irq_cnt < n && t < 300) begin @(negedge clk); t++; end
    chk(irq_cnt >= n, tag, irq_cnt, n);
  endtask

  task automatic read_pulse();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_en = 1'b0; dbl_buf = 1'b0; rd_strobe = 1'b0;
    cycles(3);
    tx_q.delete(); exp_q.delete();
    bit_idx = 0; fall_cnt = 0; irq_cnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // line model and scoreboard monitor, all at the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_sclk && !sclk) begin
        fall_cnt++;
        if (bit_idx == 0) cur_tx = (tx_q.size() > 0) ? tx_q.pop_front() : '0;
        sdi = cur_tx[DATA_W-1-bit_idx];
        bit_idx = (bit_idx + 1) % DATA_W;
      end
      if (rx_irq) begin
        irq_cnt++;
        // R11: pulse lasts a single cycle
        chk(!prev_irq, "R11 irq width", 1, 0);
        // R3: data with full flag
        chk(buf_full, "R3 full with irq", buf_full, 1);
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected frame", rx_data, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R3 frame data", rx_data, e);
        end
      end
    end
    prev_sclk = sclk;
    prev_irq  = rx_irq;
  end

  initial begin
    wait (cyc > 20000);
    chk(1'b0, "watchdog", cyc, 20000);
    finish_run();
  end

  initial begin
    int f0, lowlen;
    sdi = 1'b0;
    do_reset();
    // R1
    chk(sclk == 1'b1, "R1 sclk", sclk, 1);
    chk(buf_full == 1'b0, "R1 full", buf_full, 0);
    chk(rx_irq == 1'b0, "R1 irq", rx_irq, 0);
    // R9: read while empty
    read_pulse();
    cycles(3);
    chk(buf_full == 1'b0 && irq_cnt == 0, "R9 empty read", {buf_full, irq_cnt[3:0]}, 0);
    // R2: disabled means no clock
    cycles(40);
    chk(fall_cnt == 0, "R2 idle no clock", fall_cnt, 0);

    // single buffer
    do_reset();
    send(8'hA5, 1); send(8'h3C, 1);
    rx_en = 1'b1;
    while (!(prev_sclk && !sclk)) @(negedge clk);
    lowlen = 0;
    while (!sclk) begin lowlen++; @(negedge clk); end
    chk(lowlen == HALF, "R2 low phase", lowlen, HALF);
    wait_irq(1, "R3 first frame");
    f0 = fall_cnt;
    cycles(60);
    chk(fall_cnt == f0, "R4 paused while full", fall_cnt, f0);
    chk(buf_full && rx_data == 8'hA5, "R4 buffer held", rx_data, 8'hA5);
    read_pulse();
    chk(buf_full == 1'b0, "R8 read clears", buf_full, 0);
    wait_irq(2, "R4 resumes after read");
    rx_en = 1'b0;
    read_pulse();
    cycles(40);
    chk(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);

    // double buffer stall
    do_reset();
    dbl_buf = 1'b1;
    send(8'h5A, 1); send(8'hC3, 1); send(8'h96, 1);
    rx_en = 1'b1;
    wait_irq(1, "R3 dbl first frame");
    f0 = fall_cnt;
    cycles(60);
    chk(fall_cnt - f0 == DATA_W, "R5 shifts while full", fall_cnt - f0, DATA_W);
    f0 = fall_cnt;
    cycles(30);
    chk(fall_cnt == f0, "R6 clock stopped", fall_cnt, f0);
    chk(irq_cnt == 1 && rx_data == 8'h5A, "R6 no irq on stall", rx_data, 8'h5A);
    read_pulse();
    wait_irq(2, "R7 stalled read delivers");
    chk(buf_full == 1'b1, "R7 full stays set", buf_full, 1);
    cycles(60);
    chk(fall_cnt - f0 == DATA_W, "R7 clock resumes", fall_cnt - f0, DATA_W);
    chk(irq_cnt == 2, "R6 second stall quiet", irq_cnt, 2);
    rx_en = 1'b0;
    read_pulse();
    wait_irq(3, "R7 third frame");
    read_pulse();
    chk(buf_full == 1'b0, "R8 dbl read clears", buf_full, 0);
    chk(exp_q.size() == 0, "R7 all frames seen", exp_q.size(), 0);

    // R10: abort mid-frame
    do_reset();
    dbl_buf = 1'b1;
    send(8'hFF, 0);
    rx_en = 1'b1;
    while (fall_cnt < 3) @(negedge clk);
    rx_en = 1'b0;
    cycles(30);
    chk(fall_cnt == 3, "R10 stops after bit", fall_cnt, 3);
    chk(irq_cnt == 0 && sclk == 1'b1, "R10 no partial frame", irq_cnt, 0);
    bit_idx = 0;
    send(8'h81, 1);
    rx_en = 1'b1;
    wait_irq(1, "R10 fresh frame");
    chk(rx_data == 8'h81, "R10 aligned data", rx_data, 8'h81);
    rx_en = 1'b0;
    cycles(40);
    chk(irq_cnt == 1, "R10 single delivery", irq_cnt, 1);

    finish_run();
  end
endmodule